// File: doc/BRIEF.md
# Black-Level Measurement Strobe Generator

This block times the sampling of the black level for an offset-correction loop. It watches a clamp pulse and raises a measurement strobe for a fixed run of clock cycles. The strobe either starts as soon as the clamp begins, or it starts a selectable number of clocks after the clamp has ended. While the strobe is high, the block adds up the incoming sample words. When the run is over it divides the sum by the run length, presents the average and pulses a done flag for one cycle.

The clamp input is sampled on every rising clock edge. A *clamp start* is an edge at which the clamp is seen high after it was seen low at the edge before. A *clamp end* is an edge at which the clamp is seen low after it was seen high. The edge that starts a measurement is called the trigger edge T. The mode select and the delay select are read at that edge. Once a measurement has begun, further clamp activity is ignored until the measurement is complete. The offset loop that uses the average is a separate block.

Top module: `meas_win_top`

## Requirements
- R1: While reset is asserted (rstN low), measStrobe, avgDone and avgOut are all 0.
- R2: With afterClampMode = 0, a clamp start at edge T makes measStrobe high in exactly the 6 cycles that follow edges T through T+5. measStrobe is low after edge T+6.
- R3: With afterClampMode = 0, a clamp pulse shorter than 6 clocks still produces the full 6-cycle strobe.
- R4: With afterClampMode = 1 and longDelaySel = 0, a clamp end at edge T makes measStrobe high in the 6 cycles that follow edges T+10 through T+15. A clamp start does not trigger in this mode.
- R5: With afterClampMode = 1 and longDelaySel = 1, a clamp end at edge T makes measStrobe high in the 6 cycles that follow edges T+16 through T+21.
- R6: With afterClampMode = 0, longDelaySel has no effect: the strobe timing is that of R2 for either value.
- R7: The average is floor(S/6), where S is the sum of the sampleIn values presented in the 6 cycles in which measStrobe is high. avgOut shows this average in the cycle that follows the last strobe cycle.
- R8: avgDone is high for exactly one cycle, the cycle right after the last strobe cycle. avgOut holds its value until the next avgDone.
- R9: A clamp start or clamp end at any edge from T+1 up to and including the edge that ends the strobe starts no new measurement. This covers both the waiting period and the strobe itself.
- R10: measStrobe never stays high for more than 6 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clampIn | input | 1 | Clamp pulse, active high |
| afterClampMode | input | 1 | 0: measure from the clamp start; 1: measure after the clamp end |
| longDelaySel | input | 1 | Delay after the clamp end when afterClampMode = 1 (0: 10 clocks, 1: 16 clocks) |
| sampleIn | input | 8 | Black-level sample word |
| measStrobe | output | 1 | High while samples are being taken |
| avgOut | output | 8 | Average of the last six samples |
| avgDone | output | 1 | One-cycle pulse when avgOut is updated |

## Verification
A wrong delay count or phase count shows up directly on measStrobe. The strobe then starts or ends one or more cycles away from the expected edge, and this is visible within 22 cycles of the trigger. A corrupted accumulator, or a first-sample flag in the wrong cycle, shows up as a wrong avgOut in the cycle after the strobe falls. A state machine that accepts triggers while busy shows up later, as a second strobe run in the idle tail that follows each measurement. The sweep covers both modes, both delay values, clamp widths both shorter and longer than the run, and sample patterns that reach the largest possible sum.

// File: rtl/meas_win_pkg.sv
package meas_win_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2
  } winState_t;

  typedef struct packed {
    logic sampleEn;
    logic firstSample;
    logic finish;
  } dpCtrl_t;

endpackage

// File: rtl/meas_win_ctrl.sv
module meas_win_ctrl
  import meas_win_pkg::*;
#(
  parameter int MEAS_LEN  = 6,
  parameter int DLY_SHORT = 10,
  parameter int DLY_LONG  = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clampIn,
  input  logic    afterClampMode,
  input  logic    longDelaySel,
  output logic    measStrobe,
  output dpCtrl_t dpCtrl
);

  localparam int MAX_CNT = (DLY_LONG > MEAS_LEN) ? DLY_LONG : MEAS_LEN;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(MEAS_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(DLY_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(DLY_LONG - 1);

  winState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             clampD;
  logic             trigRise;
  logic             trigFall;
  logic [CNT_W-1:0] delayLoad;

  assign trigRise  = clampIn & ~clampD;
  assign trigFall  = ~clampIn & clampD;
  assign delayLoad = longDelaySel ? LONG_LOAD : SHORT_LOAD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clampD <= 1'b0;
      state  <= ST_IDLE;
      cnt    <= '0;
    end else begin
      clampD <= clampIn;
      unique case (state)
        ST_IDLE: begin
          if (!afterClampMode && trigRise) begin
            state <= ST_MEAS;
            cnt   <= '0;
          end else if (afterClampMode && trigFall) begin
            state <= ST_WAIT;
            cnt   <= delayLoad;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state <= ST_MEAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_MEAS: begin
          if (cnt == LAST_PHASE) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    measStrobe         = (state == ST_MEAS);
    dpCtrl.sampleEn    = (state == ST_MEAS);
    dpCtrl.firstSample = (state == ST_MEAS) && (cnt == '0);
    dpCtrl.finish      = (state == ST_MEAS) && (cnt == LAST_PHASE);
  end

endmodule

// File: rtl/meas_win_dp.sv
module meas_win_dp
  import meas_win_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MEAS_LEN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] avgOut,
  output logic              avgDone
);

  localparam int LEN_LOG = $clog2(MEAS_LEN);
  localparam int SUM_W   = DATA_W + LEN_LOG;

  logic [SUM_W-1:0]  acc;
  logic [SUM_W-1:0]  sumNext;
  logic [DATA_W-1:0] quotient;

  assign sumNext = dpCtrl.firstSample ? SUM_W'(sampleIn) : acc + SUM_W'(sampleIn);

  generate
    if ((MEAS_LEN & (MEAS_LEN - 1)) == 0) begin : g_shiftDiv
      logic [SUM_W-1:0] shifted;
      assign shifted  = sumNext >> LEN_LOG;
      assign quotient = shifted[DATA_W-1:0];
    end else begin : g_recipDiv
      localparam int SHIFT   = SUM_W + LEN_LOG;
      localparam int RECIP_W = SHIFT + 1;
      localparam int PROD_W  = SUM_W + RECIP_W;
      localparam logic [63:0] RECIP_FULL = ((64'd1 << SHIFT) + 64'(MEAS_LEN) - 64'd1) / 64'(MEAS_LEN);
      localparam logic [RECIP_W-1:0] RECIP = RECIP_FULL[RECIP_W-1:0];
      logic [PROD_W-1:0] prod;
      logic [PROD_W-1:0] shifted;
      assign prod     = PROD_W'(sumNext) * PROD_W'(RECIP);
      assign shifted  = prod >> SHIFT;
      assign quotient = shifted[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      avgOut  <= '0;
      avgDone <= 1'b0;
    end else begin
      avgDone <= dpCtrl.finish;
      if (dpCtrl.sampleEn) begin
        acc <= sumNext;
      end
      if (dpCtrl.finish) begin
        avgOut <= quotient;
      end
    end
  end

endmodule

// File: rtl/meas_win_top.sv
module meas_win_top
  import meas_win_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MEAS_LEN  = 6,
  parameter int DLY_SHORT = 10,
  parameter int DLY_LONG  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clampIn,
  input  logic              afterClampMode,
  input  logic              longDelaySel,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              measStrobe,
  output logic [DATA_W-1:0] avgOut,
  output logic              avgDone
);

  dpCtrl_t dpCtrl;

  meas_win_ctrl #(
    .MEAS_LEN (MEAS_LEN),
    .DLY_SHORT(DLY_SHORT),
    .DLY_LONG (DLY_LONG)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .clampIn       (clampIn),
    .afterClampMode(afterClampMode),
    .longDelaySel  (longDelaySel),
    .measStrobe    (measStrobe),
    .dpCtrl        (dpCtrl)
  );

  meas_win_dp #(
    .DATA_W  (DATA_W),
    .MEAS_LEN(MEAS_LEN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .sampleIn(sampleIn),
    .avgOut  (avgOut),
    .avgDone (avgDone)
  );

endmodule

// File: rtl/meas_win_chk.sv
module meas_win_chk #(
  parameter int DATA_W   = 8,
  parameter int MEAS_LEN = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              clampIn,
  input logic              afterClampMode,
  input logic              measStrobe,
  input logic [DATA_W-1:0] avgOut,
  input logic              avgDone
);

  localparam int RUN_W = $clog2(MEAS_LEN + 2) + 1;

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (measStrobe) begin
      runCnt <= runCnt + 1'b1;
    end else begin
      runCnt <= '0;
    end
  end

  // R2: a strobe run that ends has lasted exactly MEAS_LEN cycles
  p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(measStrobe) |-> (runCnt == RUN_W'(MEAS_LEN)));

  // R10: the strobe never runs longer than MEAS_LEN cycles
  p_strobe_max_r10: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_W'(MEAS_LEN));

  // R2: in clamp mode the strobe rises right after a clamp start
  p_clamp_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(measStrobe) && !$past(afterClampMode)) |-> ($past(clampIn) && !$past(clampIn, 2)));

  // R8: done follows the last strobe cycle
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    avgDone |-> ($past(measStrobe) && !measStrobe));

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    avgDone |=> !avgDone);

  // R8: the average holds between done pulses
  p_avg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !avgDone |-> $stable(avgOut));

endmodule

bind meas_win_top meas_win_chk #(
  .DATA_W  (DATA_W),
  .MEAS_LEN(MEAS_LEN)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .clampIn       (clampIn),
  .afterClampMode(afterClampMode),
  .measStrobe    (measStrobe),
  .avgOut        (avgOut),
  .avgDone       (avgDone)
);

// File: tb/sim_meas_win_top.sv
module sim_meas_win_top;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clampIn = 1'b0;
  logic              afterClampMode = 1'b0;
  logic              longDelaySel = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              measStrobe;
  logic [DATA_W-1:0] avgOut;
  logic              avgDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  meas_win_top u0 (
    .clk           (clk),
    .rstN          (rstN),
    .clampIn       (clampIn),
    .afterClampMode(afterClampMode),
    .longDelaySel  (longDelaySel),
    .sampleIn      (sampleIn),
    .measStrobe    (measStrobe),
    .avgOut        (avgOut),
    .avgDone       (avgDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sampleVal(input int pat, input int caseId, input int n);
    case (pat)
      0:       return (n * 37 + caseId * 91 + 13) % 256;
      1:       return 255;
      default: return (n % 2 == 1) ? 255 : 0;
    endcase
  endfunction

  // One measurement. Negedge n follows posedge n; inputs driven at negedge n feed posedge n+1.
  task automatic runCase(input int mode, input int lenSel, input int clampLen,
                         input bit extra, input int pat, input int caseId);
    int dly     = (mode == 1) ? ((lenSel == 1) ? 16 : 10) : 0;
    int trig    = (mode == 1) ? clampLen + 1 : 1;
    int sOn     = trig + dly;
    int sOff    = sOn + 5;
    int doneAt  = sOn + 6;
    int p       = sOn + 4;
    int lastN   = doneAt + 8;
    int sum     = 0;
    string tag;
    if (mode == 1) tag = (lenSel == 1) ? "R5" : "R4";
    else if (lenSel == 1) tag = "R6";
    else tag = (clampLen < 6) ? "R3" : "R2";
    afterClampMode = mode[0];
    longDelaySel   = lenSel[0];
    for (int n = 0; n <= lastN; n++) begin
      if (n >= 1) begin
        bit expStrb = (n >= sOn) && (n <= sOff);
        if (n > sOff && extra)
          check(measStrobe == expStrb, "R9", int'(measStrobe), int'(expStrb));
        else
          check(measStrobe == expStrb, tag, int'(measStrobe), int'(expStrb));
        check(avgDone == (n == doneAt), "R8", int'(avgDone), int'(n == doneAt));
        if (n == doneAt) check(int'(avgOut) == sum / 6, "R7", int'(avgOut), sum / 6);
        if (n > doneAt)  check(int'(avgOut) == sum / 6, "R8", int'(avgOut), sum / 6);
      end
      clampIn  = ((n + 1) <= clampLen) || (extra && (n + 1) >= p && (n + 1) < p + 2);
      sampleIn = DATA_W'(sampleVal(pat, caseId, n));
      if (n >= sOn && n <= sOff) sum += int'(sampleIn);
      @(negedge clk);
    end
    clampIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int caseId = 0;
    repeat (3) @(negedge clk);
    check(measStrobe == 1'b0, "R1", int'(measStrobe), 0);
    check(avgDone == 1'b0, "R1", int'(avgDone), 0);
    check(avgOut == '0, "R1", int'(avgOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int pat = 0; pat < 3; pat++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int lenSel = 0; lenSel < 2; lenSel++) begin
          for (int ci = 0; ci < 4; ci++) begin
            int clampLen = (ci == 0) ? 1 : (ci == 1) ? 3 : (ci == 2) ? 6 : 9;
            for (int ex = 0; ex < 2; ex++) begin
              if (ex == 0 || mode == 1 || clampLen <= 3) begin
                runCase(mode, lenSel, clampLen, ex[0], pat, caseId);
                caseId++;
              end
            end
          end
        end
      end
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule